// File: doc/BRIEF.md
# Audio DMA Byte Transfer Sequencer

This block sits between a bus-side DMA controller and the internal audio sample buffers. For each direction it raises a DMA request when the direction is enabled, set for DMA transfers and its buffer is ready. It then moves one byte per acknowledged bus strobe: bytes written by the host are gathered into a playback sample, and bytes of a latched capture sample are driven out on read strobes. When the final byte of a sample has moved, it pulses a per-direction sample-done strobe. The buffer uses that strobe to push the playback sample or pop the capture sample.

The selected data format sets how many bytes make one sample: 8 or 16 bits, mono or stereo. The bytes always travel lowest first. In dual-channel mode playback and capture each own a request/acknowledge pair and can run at the same time. In single-channel mode one pair is shared, and the direction is chosen only through the two enable bits. A sample already in progress always completes before the pair changes hands.

Top module: `audio_dma_seq`

## Requirements
- R1: The sample length in bytes follows {cfg_wide, cfg_stereo}: 00 gives 1, 01 gives 2, 10 gives 2, 11 gives 4. A sample completes on exactly that many accepted strobes.
- R2: Byte k of a sample (k = 0 first) is bits [8k+7:8k] of the sample word. The low half is the left channel. So in 16-bit formats the low byte moves before the high byte, and left moves before right.
- R3: Playback takes bus_din on each accepted write strobe. In the cycle after the final byte, pb_smp_done is high for exactly one cycle and pb_smp_data holds the assembled sample, with the bytes the format does not use at zero.
- R4: Capture latches cap_smp_data on the clock edge that raises its request. Each accepted read strobe drives byte k of that latched value on bus_dout in the same cycle. cap_smp_done pulses for one cycle in the cycle after the final byte.
- R5: An idle direction raises its request at the next clock edge only when all of these hold: its enable bit is 1, its programmed-I/O bit is 0, and its buffer is ready (pb_space for playback, cap_avail for capture). It never raises in the cycle that carries its own sample-done pulse.
- R6: A raised request stays high until the edge that ends the cycle holding the final accepted strobe of the sample, even if the enable bit clears. It is then low for at least one cycle.
- R7: A strobe is accepted only when the direction's request is high and its acknowledge is high in the same cycle. Strobes without both move no byte and change no state.
- R8: With cfg_single = 0, playback uses pb_drq/pb_dak and capture uses cap_drq/cap_dak, and both can transfer at the same time.
- R9: With cfg_single = 1, pb_drq/pb_dak serve both directions and cap_drq stays 0 while cap_dak is ignored. Playback owns the pair when cfg_pb_en is 1, otherwise capture does. A direction with a sample in progress keeps the pair until that sample completes.
- R10: bus_en is high in any cycle where a raised request meets its acknowledge. bus_dir is 1 when that is capture and 0 otherwise. bus_dout is zero except during an accepted capture read.
- R11: During reset both requests, both done pulses, bus_en, bus_dir and bus_dout are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 16-bit samples, 0 selects 8-bit |
| cfg_stereo | input | 1 | 1 selects stereo, 0 selects mono |
| cfg_single | input | 1 | 1 selects one shared request/acknowledge pair |
| cfg_pb_en | input | 1 | Playback enable |
| cfg_cap_en | input | 1 | Capture enable |
| cfg_pb_pio | input | 1 | Playback programmed-I/O select (0 = DMA) |
| cfg_cap_pio | input | 1 | Capture programmed-I/O select (0 = DMA) |
| pb_space | input | 1 | Playback buffer can take a sample |
| pb_smp_data | output | 32 | Assembled playback sample |
| pb_smp_done | output | 1 | One-cycle pulse: playback sample complete |
| cap_avail | input | 1 | Capture buffer holds a sample |
| cap_smp_data | input | 32 | Capture sample offered by the buffer |
| cap_smp_done | output | 1 | One-cycle pulse: capture sample consumed |
| pb_drq | output | 1 | Playback request (shared request in single mode) |
| pb_dak | input | 1 | Playback acknowledge (shared in single mode) |
| cap_drq | output | 1 | Capture request (dual mode only) |
| cap_dak | input | 1 | Capture acknowledge (dual mode only) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_din | input | 8 | Byte written by the host |
| bus_dout | output | 8 | Byte returned to the host |
| bus_en | output | 1 | Data bus enable |
| bus_dir | output | 1 | Data direction, 1 = toward the host |

## Verification
The hardest state to reach is a single-channel handover while a sample is still in progress. Capture already owns the shared pair when playback becomes enabled, so the shared request has to stay with capture until its last byte and only then pass to playback. The stimulus lets a capture request rise, turns playback on before any byte moves, and then completes the capture sample through the shared acknowledge. A reference model compares the requests, the bus outputs and the done pulses on every cycle. The same model also covers stray strobes sent before the acknowledge and after the request drops, and a playback sample and a capture sample that overlap in dual mode.

// File: rtl/adma_pkg.sv
package adma_pkg;

  // Largest sample: 16-bit stereo, four bytes
  localparam int unsigned ADMA_NBYTE_MAX = 4;
  localparam int unsigned ADMA_CNT_W     = $clog2(ADMA_NBYTE_MAX) + 1;

  typedef struct packed {
    logic wide;    // 16-bit samples
    logic stereo;  // two channels
  } adma_fmt_t;

  function automatic logic [ADMA_CNT_W-1:0] adma_nbytes(input adma_fmt_t fmt);
    logic [ADMA_CNT_W-1:0] n;
    case ({fmt.wide, fmt.stereo})
      2'b00:   n = ADMA_CNT_W'(1);
      2'b01:   n = ADMA_CNT_W'(2);
      2'b10:   n = ADMA_CNT_W'(2);
      default: n = ADMA_CNT_W'(4);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/adma_rst_sync.sv
module adma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_n;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/adma_engine.sv
module adma_engine #(
  parameter int NBYTE_MAX = 4,
  localparam int IDX_W = $clog2(NBYTE_MAX),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] n_bytes,
  input  logic             can_raise,
  input  logic             ack,
  input  logic             stb,
  output logic             req,
  output logic             raise,
  output logic             xfer,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  logic             req_q, req_n;
  logic             done_q, done_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             idx_en;
  logic             last;

  always_comb begin
    xfer   = req_q & ack & stb;
    last   = ({1'b0, idx_q} == (n_bytes - CNT_W'(1)));
    raise  = can_raise & ~req_q & ~done_q;
    idx_en = xfer;
    idx_n  = last ? '0 : idx_q + 1'b1;
    done_n = xfer & last;
    req_n  = req_q;
    if (raise)          req_n = 1'b1;
    else if (xfer && last) req_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      req_q  <= req_n;
      done_q <= done_n;
      if (idx_en) idx_q <= idx_n;
    end
  end

  assign req  = req_q;
  assign idx  = idx_q;
  assign done = done_q;

  // R6: the final accepted byte always drops the request
  p_req_drop_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last) |=> !req_q);

  // R6: a request only falls because a sample completed
  p_req_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(xfer && last));

  // R3 / R4: sample-done is a single-cycle pulse
  p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: a request rises only with a grant in the previous cycle
  p_raise_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(can_raise));

  // R1: byte position stays inside the sample length
  p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ({1'b0, idx_q} < n_bytes));

endmodule

// File: rtl/adma_pack.sv
module adma_pack #(
  parameter int BYTE_W    = 8,
  parameter int NBYTE_MAX = 4,
  localparam int IDX_W = $clog2(NBYTE_MAX),
  localparam int SMP_W = BYTE_W * NBYTE_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] din,
  output logic [SMP_W-1:0]  smp
);

  logic [SMP_W-1:0] asm_q, asm_n;
  logic             asm_en;

  always_comb begin
    asm_en = start | wr_en;
    asm_n  = asm_q;
    if (start) asm_n = '0;
    else       asm_n[idx*BYTE_W +: BYTE_W] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      asm_q <= '0;
    else if (asm_en) asm_q <= asm_n;
  end

  assign smp = asm_q;

  // R3: a new sample starts from an all-zero word
  p_clear_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_en) |=> (smp == '0));

  // R7: without an accepted strobe or a new sample, the word holds
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wr_en) |=> $stable(smp));

endmodule

// File: rtl/adma_unpack.sv
module adma_unpack #(
  parameter int BYTE_W    = 8,
  parameter int NBYTE_MAX = 4,
  localparam int IDX_W = $clog2(NBYTE_MAX),
  localparam int SMP_W = BYTE_W * NBYTE_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SMP_W-1:0]  smp_in,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] dout
);

  logic [SMP_W-1:0] hold_q;
  logic             hold_en;

  always_comb begin
    hold_en = load;
    dout    = '0;
    if (rd_en) dout = hold_q[idx*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= smp_in;
  end

  // R4: the latched sample is untouched while bytes are read out
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold_q));

endmodule

// File: rtl/audio_dma_seq.sv
module audio_dma_seq #(
  parameter int BYTE_W = 8,
  localparam int NBYTE_MAX = adma_pkg::ADMA_NBYTE_MAX,
  localparam int SMP_W     = BYTE_W * NBYTE_MAX,
  localparam int IDX_W     = $clog2(NBYTE_MAX),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_stereo,
  input  logic              cfg_single,
  input  logic              cfg_pb_en,
  input  logic              cfg_cap_en,
  input  logic              cfg_pb_pio,
  input  logic              cfg_cap_pio,
  input  logic              pb_space,
  output logic [SMP_W-1:0]  pb_smp_data,
  output logic              pb_smp_done,
  input  logic              cap_avail,
  input  logic [SMP_W-1:0]  cap_smp_data,
  output logic              cap_smp_done,
  output logic              pb_drq,
  input  logic              pb_dak,
  output logic              cap_drq,
  input  logic              cap_dak,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_din,
  output logic [BYTE_W-1:0] bus_dout,
  output logic              bus_en,
  output logic              bus_dir
);

  import adma_pkg::*;

  logic             rst_n_i;
  adma_fmt_t        fmt;
  logic [CNT_W-1:0] n_bytes;

  logic             pb_can, cap_can;
  logic             pb_ack_eff, cap_ack_eff;
  logic             pb_req, cap_req;
  logic             pb_raise, cap_raise;
  logic             pb_xfer, cap_xfer;
  logic [IDX_W-1:0] pb_idx, cap_idx;

  adma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    fmt.wide   = cfg_wide;
    fmt.stereo = cfg_stereo;
    n_bytes    = adma_nbytes(fmt);
    // shared pair in single mode: its acknowledge serves whichever side owns it
    pb_ack_eff  = pb_dak;
    cap_ack_eff = cfg_single ? pb_dak : cap_dak;
    pb_can  = cfg_pb_en & ~cfg_pb_pio & pb_space &
              (~cfg_single | ~cap_req);
    cap_can = cfg_cap_en & ~cfg_cap_pio & cap_avail &
              (~cfg_single | (~cfg_pb_en & ~pb_req));
    pb_drq  = pb_req | (cfg_single & cap_req);
    cap_drq = ~cfg_single & cap_req;
    bus_en  = (pb_req & pb_ack_eff) | (cap_req & cap_ack_eff);
    bus_dir = cap_req & cap_ack_eff;
  end

  adma_engine #(.NBYTE_MAX(NBYTE_MAX)) u_pb_eng (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .n_bytes   (n_bytes),
    .can_raise (pb_can),
    .ack       (pb_ack_eff),
    .stb       (bus_wr),
    .req       (pb_req),
    .raise     (pb_raise),
    .xfer      (pb_xfer),
    .idx       (pb_idx),
    .done      (pb_smp_done)
  );

  adma_engine #(.NBYTE_MAX(NBYTE_MAX)) u_cap_eng (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .n_bytes   (n_bytes),
    .can_raise (cap_can),
    .ack       (cap_ack_eff),
    .stb       (bus_rd),
    .req       (cap_req),
    .raise     (cap_raise),
    .xfer      (cap_xfer),
    .idx       (cap_idx),
    .done      (cap_smp_done)
  );

  adma_pack #(.BYTE_W(BYTE_W), .NBYTE_MAX(NBYTE_MAX)) u_pack (
    .clk   (clk),
    .rst_n (rst_n_i),
    .start (pb_raise),
    .wr_en (pb_xfer),
    .idx   (pb_idx),
    .din   (bus_din),
    .smp   (pb_smp_data)
  );

  adma_unpack #(.BYTE_W(BYTE_W), .NBYTE_MAX(NBYTE_MAX)) u_unpack (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .load   (cap_raise),
    .smp_in (cap_smp_data),
    .rd_en  (cap_xfer),
    .idx    (cap_idx),
    .dout   (bus_dout)
  );

  // R9: the shared pair never has two owners
  p_single_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    cfg_single |-> !(pb_req && cap_req));

  // R9: the capture request pin is quiet in single mode
  p_single_cap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    cfg_single |-> !cap_drq);

  // R10: the data bus is enabled only for an owner of a raised request
  p_bus_en_owner_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_en |-> (pb_drq || cap_drq));

  // R10: a direction toward the host only during an enabled cycle
  p_dir_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_dir |-> bus_en);

endmodule

// File: tb/tb_audio_dma_seq.sv
module tb_audio_dma_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wide, cfg_stereo, cfg_single;
  logic        cfg_pb_en, cfg_cap_en, cfg_pb_pio, cfg_cap_pio;
  logic        pb_space, cap_avail;
  logic [31:0] pb_smp_data, cap_smp_data;
  logic        pb_smp_done, cap_smp_done;
  logic        pb_drq, pb_dak, cap_drq, cap_dak;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_din, bus_dout;
  logic        bus_en, bus_dir;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  audio_dma_seq dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wide(cfg_wide), .cfg_stereo(cfg_stereo), .cfg_single(cfg_single),
    .cfg_pb_en(cfg_pb_en), .cfg_cap_en(cfg_cap_en),
    .cfg_pb_pio(cfg_pb_pio), .cfg_cap_pio(cfg_cap_pio),
    .pb_space(pb_space), .pb_smp_data(pb_smp_data), .pb_smp_done(pb_smp_done),
    .cap_avail(cap_avail), .cap_smp_data(cap_smp_data), .cap_smp_done(cap_smp_done),
    .pb_drq(pb_drq), .pb_dak(pb_dak), .cap_drq(cap_drq), .cap_dak(cap_dak),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_en(bus_en), .bus_dir(bus_dir)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", what, act, exp, cyc);
    end
  endtask

  function automatic int fmt_len();
    return cfg_wide ? (cfg_stereo ? 4 : 2) : (cfg_stereo ? 2 : 1);
  endfunction

  // ---------------- behavioural reference model ----------------
  bit          m_pr, m_pd, m_cr, m_cd;
  int          m_pi, m_ci;
  logic [31:0] m_pbuf, m_cbuf;
  logic [31:0] m_pout[$];
  bit          t_px, t_cx, t_pc, t_cc, t_pd0, t_cd0, t_ack;
  int          t_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pr = 0; m_pd = 0; m_cr = 0; m_cd = 0; m_pi = 0; m_ci = 0;
      m_pbuf = '0; m_cbuf = '0;
    end else begin
      t_n   = fmt_len();
      t_ack = cfg_single ? pb_dak : cap_dak;
      t_px  = m_pr && pb_dak && bus_wr;
      t_cx  = m_cr && t_ack && bus_rd;
      t_pc  = cfg_pb_en && !cfg_pb_pio && pb_space && (!cfg_single || !m_cr);
      t_cc  = cfg_cap_en && !cfg_cap_pio && cap_avail &&
              (!cfg_single || (!cfg_pb_en && !m_pr));
      t_pd0 = m_pd; t_cd0 = m_cd;
      m_pd = 0; m_cd = 0;
      if (t_px) begin
        m_pbuf[8*m_pi +: 8] = bus_din;
        if (m_pi == t_n - 1) begin
          m_pd = 1; m_pr = 0; m_pi = 0; m_pout.push_back(m_pbuf);
        end else m_pi++;
      end else if (!m_pr && !t_pd0 && t_pc) begin
        m_pr = 1; m_pbuf = '0;
      end
      if (t_cx) begin
        if (m_ci == t_n - 1) begin
          m_cd = 1; m_cr = 0; m_ci = 0;
        end else m_ci++;
      end else if (!m_cr && !t_cd0 && t_cc) begin
        m_cr = 1; m_cbuf = cap_smp_data;
      end
    end
  end

  // per-cycle comparison, away from the clock edge
  bit          e_cack, e_den;
  logic [31:0] e_pdata;
  always @(negedge clk) begin
    #5;
    e_cack = cfg_single ? pb_dak : cap_dak;
    e_den  = m_cr && e_cack;
    chk("R6 pb_drq", pb_drq, m_pr || (cfg_single && m_cr));
    chk("R9 cap_drq", cap_drq, !cfg_single && m_cr);
    chk("R10 bus_en", bus_en, (m_pr && pb_dak) || (m_cr && e_cack));
    chk("R10 bus_dir", bus_dir, e_den);
    chk("R4 bus_dout", bus_dout,
        (e_den && bus_rd) ? m_cbuf[8*m_ci +: 8] : 8'h00);
    chk("R3 pb_smp_done", pb_smp_done, m_pd);
    chk("R4 cap_smp_done", cap_smp_done, m_cd);
    if (m_pd) begin
      e_pdata = m_pout.pop_front();
      chk("R3 pb_smp_data", pb_smp_data, e_pdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=%0d expected<%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] keep_bytes(input logic [31:0] w, input int n);
    return (n == 4) ? w : (w & ((32'h1 << (8 * n)) - 1));
  endfunction

  task automatic pb_sample(input logic [31:0] word, input string tag);
    int n = fmt_len();
    while (!pb_drq) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      pb_dak = 1; bus_wr = 1; bus_din = word[8*i +: 8];
      @(negedge clk);
    end
    pb_dak = 0; bus_wr = 0; bus_din = 8'hEE;
    #1;
    chk({tag, " R1 done after format length"}, pb_smp_done, 1'b1);
    chk({tag, " R2 byte order"}, pb_smp_data, keep_bytes(word, n));
  endtask

  task automatic cap_sample(input logic [31:0] word, input bit shared, input string tag);
    int n = fmt_len();
    cap_smp_data = word;
    while (!(shared ? pb_drq : cap_drq)) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (shared) pb_dak = 1; else cap_dak = 1;
      bus_rd = 1;
      #1;
      chk({tag, " R2 R4 read byte"}, bus_dout, word[8*i +: 8]);
      @(negedge clk);
    end
    if (shared) pb_dak = 0; else cap_dak = 0;
    bus_rd = 0;
    #1;
    chk({tag, " R4 capture done"}, cap_smp_done, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    cfg_wide = 0; cfg_stereo = 0; cfg_single = 0;
    cfg_pb_en = 0; cfg_cap_en = 0; cfg_pb_pio = 0; cfg_cap_pio = 0;
    pb_space = 0; cap_avail = 0; cap_smp_data = '0;
    pb_dak = 0; cap_dak = 0; bus_rd = 0; bus_wr = 0; bus_din = '0;
    idle(3);
    #1;
    chk("R11 pb_drq in reset", pb_drq, 0);
    chk("R11 cap_drq in reset", cap_drq, 0);
    chk("R11 bus_en in reset", bus_en, 0);
    chk("R11 done pulses in reset", {pb_smp_done, cap_smp_done}, 0);
    rst_n = 1;
    idle(4);

    // R5: programmed-I/O and missing space block the request
    cfg_pb_en = 1; cfg_pb_pio = 1; pb_space = 1;
    idle(4); #1;
    chk("R5 no request with pio set", pb_drq, 0);
    cfg_pb_pio = 0; pb_space = 0;
    idle(4); #1;
    chk("R5 no request without space", pb_drq, 0);
    pb_space = 1;
    idle(1); #1;
    chk("R5 request one edge after ready", pb_drq, 1);

    // R1 R2 R3: playback in all four formats, dual mode
    for (int f = 0; f < 4; f++) begin
      cfg_wide = f[1]; cfg_stereo = f[0];
      pb_sample(32'hA1B2C3D4 + 32'h01010101 * f, "R1 R3 playback");
    end

    // R7: stray strobes before the acknowledge and after the request drops
    cfg_wide = 1; cfg_stereo = 1;
    while (!pb_drq) @(negedge clk);
    bus_wr = 1; bus_din = 8'h55; idle(2);
    bus_wr = 0; pb_dak = 1; idle(2);
    pb_dak = 0;
    pb_sample(32'h11223344, "R7 stray strobes");
    cfg_pb_en = 0;
    idle(3);
    pb_dak = 1; bus_wr = 1; bus_din = 8'h77; idle(3);
    pb_dak = 0; bus_wr = 0; #1;
    chk("R7 no transfer without request", pb_smp_done, 0);

    // R4: capture in all four formats, dual mode
    cfg_cap_en = 1; cap_avail = 1;
    for (int f = 0; f < 4; f++) begin
      cfg_wide = f[1]; cfg_stereo = f[0];
      cap_sample(32'h5A6B7C8D ^ (32'h11111111 * f), 1'b0, "R4 capture");
    end

    // R6: clearing the enable mid-sample does not drop the request
    cfg_wide = 1; cfg_stereo = 1; cap_smp_data = 32'hCAFE0123;
    while (!cap_drq) @(negedge clk);
    cfg_cap_en = 0; idle(3); #1;
    chk("R6 request held after enable clears", cap_drq, 1);
    cap_sample(32'hCAFE0123, 1'b0, "R6 finish held sample");
    idle(3); #1;
    chk("R6 no new request after finish", cap_drq, 0);

    // R8: overlapping playback and capture on separate pairs
    cfg_pb_en = 1; cfg_cap_en = 1;
    for (int k = 0; k < 3; k++) begin
      fork
        pb_sample(32'h0F1E2D3C + k, "R8 dual playback");
        cap_sample(32'h98765432 - k, 1'b0, "R8 dual capture");
      join
    end
    cfg_pb_en = 0; cfg_cap_en = 0;
    idle(4);

    // R9: single mode, capture on the shared pair
    cfg_single = 1; cfg_cap_en = 1; cap_avail = 1;
    cap_sample(32'h13579BDF, 1'b1, "R9 single capture");
    #1;
    chk("R9 cap_drq quiet in single mode", cap_drq, 0);
    // capture raised, then playback enabled before a byte moves
    cap_smp_data = 32'h2468ACE0;
    while (!pb_drq) @(negedge clk);
    cfg_pb_en = 1; pb_space = 1;
    cap_dak = 1; bus_rd = 1; idle(2);
    cap_dak = 0; bus_rd = 0;
    cap_sample(32'h2468ACE0, 1'b1, "R9 handover capture finishes");
    cap_avail = 0;
    pb_sample(32'hDEADBEEF, "R9 handover playback");
    cfg_pb_en = 0; pb_space = 0;
    idle(4);
    cfg_wide = 0; cfg_stereo = 1; cap_avail = 1;
    cap_sample(32'h0000C3A5, 1'b1, "R9 back to capture");
    cfg_cap_en = 0; cap_avail = 0;
    idle(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule